// File: doc/BRIEF.md
# Standby Mode Controller

This block sequences the low-power states of a small 4-bit microcontroller. It takes two instruction strobes from the core (a request for hold and a request for halt), the raw level of an external hold-control pin, the raw external reset pin and a wake event, and it produces a run enable for the CPU, a core reset, and gated output data and output enables for the port groups. It also drives a separate enable for an optional dedicated inverter buffer that lives on one port group.

Three states are encoded on the `mode` output: RUN (0), HALT (1) and HOLD (2). The transitions are: RUN to HOLD when the hold strobe arrives while the synchronized hold pin is low; RUN to HALT when the halt strobe arrives and hold entry is not taken; HALT to RUN on a wake event or a core reset; HOLD to RUN when the synchronized hold pin returns high; and any state to RUN on a core reset. Both pins pass through two-flop synchronizers. The external reset pin only resets the core while the synchronized hold pin is high. This lets a system park the part in HOLD with the pin low and be sure that noise on the reset pin cannot disturb it.

In HALT the port drivers keep the data and enables they had in the last RUN cycle, and the inverter keeps working. In HOLD every port enable and the inverter enable are off. During core reset the port groups show their reset pattern. The inverter-capable group has its enables off. Each other group drives a level fixed by a parameter.

Top module: `standby_ctrl`

## Requirements
- R1: `mode` reads 0 in RUN, 1 in HALT and 2 in HOLD, and `cpu_run_en` is high only in RUN while `core_rst` is low.
- R2: A hold strobe in RUN moves the block to HOLD at the next clock only if the synchronized hold pin is low. With the pin high the strobe leaves the mode unchanged.
- R3: In HOLD, the synchronized hold pin going high returns the block to RUN at the next clock.
- R4: Both pins pass through two synchronizer flops. `core_rst` is high exactly when the synchronized reset pin is low and the synchronized hold pin is high. A low reset pin is ignored while the hold pin is low. A core reset puts the block in RUN at the next clock.
- R5: In HOLD without core reset, all bits of `port_oe` are 0 and `inv_oe` is 0.
- R6: In HALT without core reset, `port_dout` and `port_oe` keep the values of the last RUN cycle, whatever the port inputs do.
- R7: In HALT, `inv_oe` is 1 and `inv_out` keeps following the complement of `inv_in`.
- R8: A wake event or a core reset in HALT returns the block to RUN at the next clock.
- R9: While `core_rst` is high, `port_oe` is 0 for group INV_GRP (bits 7:4 by default) and all ones for the other groups. Each group's `port_dout` bits equal that group's bit of RST_LEVEL (default 4'b1011, giving 16'hF0FF).
- R10: If the hold and halt strobes arrive in the same RUN cycle, the block enters HOLD when the synchronized hold pin is low, and otherwise enters HALT.
- R11: In RUN without core reset, `port_dout` and `port_oe` equal `port_dout_in` and `port_oe_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset for the block's own flops, active low |
| rst_pin_n | input | 1 | Raw external reset pin, active low |
| hold_pin | input | 1 | Raw hold-control pin level |
| hold_req | input | 1 | Hold instruction strobe, one cycle |
| halt_req | input | 1 | Halt instruction strobe, one cycle |
| wake | input | 1 | Wake event that ends HALT |
| port_dout_in | input | GROUPS*GW | Port data from the core's port latches |
| port_oe_in | input | GROUPS*GW | Port output enables from the core |
| inv_in | input | 1 | Input of the dedicated inverter |
| mode | output | 2 | Current mode: 0 RUN, 1 HALT, 2 HOLD |
| cpu_run_en | output | 1 | CPU clock/run enable |
| core_rst | output | 1 | Gated reset to the core, active high |
| port_dout | output | GROUPS*GW | Gated port data to the pads |
| port_oe | output | GROUPS*GW | Gated port output enables to the pads |
| inv_out | output | 1 | Inverter output |
| inv_oe | output | 1 | Inverter output enable |

## Verification
The bench drives the reset pin low while the hold pin is low. A design that does not gate reset would drop `cpu_run_en` or leave HOLD. It sends a hold strobe with the pin high, and a design that ignored the pin condition would park the CPU. It sends both strobes together in each pin state, which catches a wrong priority. It also changes the port inputs during HALT and toggles the inverter input. A block that passed the inputs through, or froze the inverter, would show new port values or a stuck `inv_out`. Finally it asserts reset during HALT and checks that the reset pattern appears. This catches a design that loses the inverter group's output-off state.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HALT = 2'd1,
        MODE_HOLD = 2'd2
    } stby_mode_e;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       hold_s,
    input  logic       rst_s_n,
    input  logic       hold_req,
    input  logic       halt_req,
    input  logic       wake,
    output stby_mode_e mode,
    output logic       core_rst,
    output logic       cpu_run_en
);

    stby_mode_e state_q, state_d;

    // reset pin only takes effect while the hold pin is high
    assign core_rst = !rst_s_n && hold_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN: begin
                if (core_rst) begin
                    state_d = MODE_RUN;
                end else if (hold_req && !hold_s) begin
                    state_d = MODE_HOLD;
                end else if (halt_req) begin
                    state_d = MODE_HALT;
                end
            end
            MODE_HALT: begin
                if (core_rst || wake) begin
                    state_d = MODE_RUN;
                end
            end
            MODE_HOLD: begin
                if (hold_s) begin
                    state_d = MODE_RUN;
                end
            end
            default: state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= MODE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mode       = state_q;
        cpu_run_en = (state_q == MODE_RUN) && !core_rst;
    end

    AST_RUN_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!arst_n)
        cpu_run_en |-> state_q == MODE_RUN); // R1
    AST_HOLD_ENTRY_PIN_LOW: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_HOLD && $past(state_q) != MODE_HOLD) |-> ($past(hold_req) && !$past(hold_s))); // R2
    AST_HOLD_REFUSED_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_RUN && hold_req && hold_s) |=> state_q != MODE_HOLD); // R2
    AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_HOLD && hold_s) |=> state_q == MODE_RUN); // R3
    AST_HOLD_RST_MASKED: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_HOLD && !hold_s) |=> state_q == MODE_HOLD); // R4
    AST_CORE_RST_TO_RUN: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst |=> state_q == MODE_RUN); // R4
    AST_HALT_EXIT: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_HALT && (wake || core_rst)) |=> state_q == MODE_RUN); // R8
    AST_HOLD_PRIORITY: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == MODE_RUN && !core_rst && hold_req && halt_req && !hold_s) |=> state_q == MODE_HOLD); // R10

endmodule

// File: rtl/stby_port_gate.sv
module stby_port_gate
    import stby_pkg::*;
#(
    parameter int              GROUPS     = 4,
    parameter int              GW         = 4,
    parameter int              INV_GRP    = 1,
    parameter logic [GROUPS-1:0] RST_LEVEL = 4'b1011,
    parameter bit              INV_OPTION = 1'b1,
    localparam int             PW         = GROUPS * GW
) (
    input  logic          clk,
    input  logic          arst_n,
    input  stby_mode_e    mode,
    input  logic          core_rst,
    input  logic [PW-1:0] dout_in,
    input  logic [PW-1:0] oe_in,
    input  logic          inv_in,
    output logic [PW-1:0] port_dout,
    output logic [PW-1:0] port_oe,
    output logic          inv_out,
    output logic          inv_oe
);

    logic [PW-1:0] rst_dout, rst_oe;
    logic [PW-1:0] cap_dout_q, cap_oe_q;

    // per-group reset pattern: the inverter group comes up output-off
    for (genvar g = 0; g < GROUPS; g++) begin : g_rst_pat
        assign rst_dout[g*GW +: GW] = {GW{RST_LEVEL[g]}};
        assign rst_oe[g*GW +: GW]   = (g == INV_GRP) ? {GW{1'b0}} : {GW{1'b1}};
    end

    // capture registers track the core in RUN and freeze otherwise
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cap_dout_q <= rst_dout;
            cap_oe_q   <= rst_oe;
        end else if (core_rst) begin
            cap_dout_q <= rst_dout;
            cap_oe_q   <= rst_oe;
        end else if (mode == MODE_RUN) begin
            cap_dout_q <= dout_in;
            cap_oe_q   <= oe_in;
        end
    end

    always_comb begin
        port_dout = cap_dout_q;
        port_oe   = cap_oe_q;
        if (core_rst) begin
            port_dout = rst_dout;
            port_oe   = rst_oe;
        end else begin
            unique case (mode)
                MODE_RUN: begin
                    port_dout = dout_in;
                    port_oe   = oe_in;
                end
                MODE_HALT: begin
                    port_dout = cap_dout_q;
                    port_oe   = cap_oe_q;
                end
                MODE_HOLD: begin
                    port_dout = cap_dout_q;
                    port_oe   = '0;
                end
                default: begin
                    port_dout = cap_dout_q;
                    port_oe   = '0;
                end
            endcase
        end
    end

    always_comb begin
        inv_oe  = INV_OPTION && (mode != MODE_HOLD);
        inv_out = inv_oe ? ~inv_in : 1'b0;
    end

    AST_HOLD_PORTS_OFF: assert property (@(posedge clk) disable iff (!arst_n)
        (mode == MODE_HOLD && !core_rst) |-> (port_oe == '0 && !inv_oe)); // R5
    AST_HALT_RETAIN: assert property (@(posedge clk) disable iff (!arst_n)
        (mode == MODE_HALT && $past(mode) == MODE_HALT && !core_rst && !$past(core_rst))
        |-> ($stable(port_dout) && $stable(port_oe))); // R6
    AST_HALT_ENTRY_RETAIN: assert property (@(posedge clk) disable iff (!arst_n)
        (mode == MODE_HALT && $past(mode) == MODE_RUN && !core_rst && !$past(core_rst))
        |-> ($stable(port_dout) && $stable(port_oe))); // R6
    AST_HALT_INV_LIVE: assert property (@(posedge clk) disable iff (!arst_n)
        (mode == MODE_HALT && INV_OPTION) |-> (inv_oe && inv_out != inv_in)); // R7

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int                GROUPS      = 4,
    parameter int                GW          = 4,
    parameter int                INV_GRP     = 1,
    parameter logic [GROUPS-1:0] RST_LEVEL   = 4'b1011,
    parameter bit                INV_OPTION  = 1'b1,
    parameter int                SYNC_STAGES = 2,
    localparam int               PW          = GROUPS * GW
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_pin_n,
    input  logic          hold_pin,
    input  logic          hold_req,
    input  logic          halt_req,
    input  logic          wake,
    input  logic [PW-1:0] port_dout_in,
    input  logic [PW-1:0] port_oe_in,
    input  logic          inv_in,
    output logic [1:0]    mode,
    output logic          cpu_run_en,
    output logic          core_rst,
    output logic [PW-1:0] port_dout,
    output logic [PW-1:0] port_oe,
    output logic          inv_out,
    output logic          inv_oe
);

    logic       hold_s;
    logic       rst_s_n;
    stby_mode_e mode_e;

    stby_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_hold_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (hold_pin),
        .q      (hold_s)
    );

    stby_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_rst_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (rst_pin_n),
        .q      (rst_s_n)
    );

    stby_mode_fsm i_fsm (
        .clk        (clk),
        .arst_n     (por_n),
        .hold_s     (hold_s),
        .rst_s_n    (rst_s_n),
        .hold_req   (hold_req),
        .halt_req   (halt_req),
        .wake       (wake),
        .mode       (mode_e),
        .core_rst   (core_rst),
        .cpu_run_en (cpu_run_en)
    );

    stby_port_gate #(
        .GROUPS     (GROUPS),
        .GW         (GW),
        .INV_GRP    (INV_GRP),
        .RST_LEVEL  (RST_LEVEL),
        .INV_OPTION (INV_OPTION)
    ) i_gate (
        .clk       (clk),
        .arst_n    (por_n),
        .mode      (mode_e),
        .core_rst  (core_rst),
        .dout_in   (port_dout_in),
        .oe_in     (port_oe_in),
        .inv_in    (inv_in),
        .port_dout (port_dout),
        .port_oe   (port_oe),
        .inv_out   (inv_out),
        .inv_oe    (inv_oe)
    );

    assign mode = mode_e;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
        mode != 2'd3); // R1

endmodule

// File: tb/test_standby_ctrl.sv
module test_standby_ctrl;

    localparam logic [15:0] RST_OE   = 16'hFF0F;
    localparam logic [15:0] RST_DOUT = 16'hF0FF;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin_n = 1'b0;
    logic        hold_pin = 1'b1;
    logic        hold_req = 1'b0;
    logic        halt_req = 1'b0;
    logic        wake = 1'b0;
    logic [15:0] port_dout_in = 16'h0000;
    logic [15:0] port_oe_in = 16'h0000;
    logic        inv_in = 1'b0;
    logic [1:0]  mode;
    logic        cpu_run_en, core_rst, inv_out, inv_oe;
    logic [15:0] port_dout, port_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    standby_ctrl i_standby_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .rst_pin_n    (rst_pin_n),
        .hold_pin     (hold_pin),
        .hold_req     (hold_req),
        .halt_req     (halt_req),
        .wake         (wake),
        .port_dout_in (port_dout_in),
        .port_oe_in   (port_oe_in),
        .inv_in       (inv_in),
        .mode         (mode),
        .cpu_run_en   (cpu_run_en),
        .core_rst     (core_rst),
        .port_dout    (port_dout),
        .port_oe      (port_oe),
        .inv_out      (inv_out),
        .inv_oe       (inv_oe)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_hold_halt(input logic h, input logic t);
        cycles(1);
        hold_req = h;
        halt_req = t;
        cycles(1);
        hold_req = 1'b0;
        halt_req = 1'b0;
    endtask

    task automatic pulse_wake();
        cycles(1);
        wake = 1'b1;
        cycles(1);
        wake = 1'b0;
    endtask

    task automatic test_reset_state();
        cycles(4);
        check("R9 reset oe", 32'(port_oe), 32'(RST_OE));
        check("R9 reset dout", 32'(port_dout), 32'(RST_DOUT));
        check("R4 core_rst at power-up", 32'(core_rst), 32'd1);
        check("R1 no run in reset", 32'(cpu_run_en), 32'd0);
        por_n = 1'b1;
        cycles(3);
        check("R4 pin still low keeps reset", 32'(core_rst), 32'd1);
        rst_pin_n = 1'b1;
        cycles(3);
        check("R4 reset released", 32'(core_rst), 32'd0);
        check("R1 run mode code", 32'(mode), 32'd0);
        check("R1 run enable", 32'(cpu_run_en), 32'd1);
    endtask

    task automatic test_run_pass();
        port_dout_in = 16'h5A3C;
        port_oe_in   = 16'hC3F0;
        cycles(1);
        check("R11 run dout", 32'(port_dout), 32'h5A3C);
        check("R11 run oe", 32'(port_oe), 32'hC3F0);
        inv_in = 1'b1;
        cycles(1);
        check("R7 inverter in run", 32'(inv_out), 32'd0);
    endtask

    task automatic test_reset_mask_and_hold();
        hold_pin = 1'b0;
        cycles(3);
        rst_pin_n = 1'b0;
        cycles(4);
        check("R4 reset masked", 32'(core_rst), 32'd0);
        check("R4 cpu keeps running", 32'(cpu_run_en), 32'd1);
        pulse_hold_halt(1'b1, 1'b0);
        check("R2 hold entered", 32'(mode), 32'd2);
        check("R1 cpu stopped in hold", 32'(cpu_run_en), 32'd0);
        check("R5 ports off", 32'(port_oe), 32'd0);
        check("R5 inverter off", 32'(inv_oe), 32'd0);
        cycles(4);
        check("R4 hold kept despite reset pin", 32'(mode), 32'd2);
        rst_pin_n = 1'b1;
        cycles(3);
        hold_pin = 1'b1;
        cycles(2);
        check("R3 still hold before sync", 32'(mode), 32'd2);
        cycles(1);
        check("R3 restart to run", 32'(mode), 32'd0);
        check("R3 run enable back", 32'(cpu_run_en), 32'd1);
    endtask

    task automatic test_hold_refused();
        pulse_hold_halt(1'b1, 1'b0);
        check("R2 hold refused with pin high", 32'(mode), 32'd0);
        check("R2 cpu still running", 32'(cpu_run_en), 32'd1);
    endtask

    task automatic test_priority();
        hold_pin = 1'b0;
        cycles(3);
        pulse_hold_halt(1'b1, 1'b1);
        check("R10 hold wins with pin low", 32'(mode), 32'd2);
        hold_pin = 1'b1;
        cycles(4);
        check("R3 back to run", 32'(mode), 32'd0);
        pulse_hold_halt(1'b1, 1'b1);
        check("R10 halt taken with pin high", 32'(mode), 32'd1);
        pulse_wake();
        check("R8 wake exits halt", 32'(mode), 32'd0);
    endtask

    task automatic test_halt_retain();
        port_dout_in = 16'h1234;
        port_oe_in   = 16'h0FF0;
        pulse_hold_halt(1'b0, 1'b1);
        check("R1 halt mode code", 32'(mode), 32'd1);
        port_dout_in = 16'hBEEF;
        port_oe_in   = 16'hFFFF;
        cycles(2);
        check("R6 dout retained", 32'(port_dout), 32'h1234);
        check("R6 oe retained", 32'(port_oe), 32'h0FF0);
        inv_in = 1'b0;
        cycles(1);
        check("R7 inverter live high", 32'(inv_out), 32'd1);
        check("R7 inverter enabled", 32'(inv_oe), 32'd1);
        inv_in = 1'b1;
        cycles(1);
        check("R7 inverter live low", 32'(inv_out), 32'd0);
        pulse_wake();
        check("R8 wake to run", 32'(mode), 32'd0);
        cycles(1);
        check("R11 new data after wake", 32'(port_dout), 32'hBEEF);
    endtask

    task automatic test_halt_reset();
        pulse_hold_halt(1'b0, 1'b1);
        check("R8 in halt before reset", 32'(mode), 32'd1);
        rst_pin_n = 1'b0;
        cycles(3);
        check("R8 reset exits halt", 32'(mode), 32'd0);
        check("R4 core reset active", 32'(core_rst), 32'd1);
        check("R9 reset oe pattern", 32'(port_oe), 32'(RST_OE));
        check("R9 reset dout pattern", 32'(port_dout), 32'(RST_DOUT));
        rst_pin_n = 1'b1;
        cycles(4);
        check("R1 running after reset", 32'(cpu_run_en), 32'd1);
    endtask

    initial begin
        test_reset_state();
        test_run_pass();
        test_reset_mask_and_hold();
        test_hold_refused();
        test_priority();
        test_halt_retain();
        test_halt_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule